// File: doc/BRIEF.md
# Interruptible Local-Bus Block Transfer Engine

This block copies a run of bytes between a Dword-wide internal memory port and a narrow external local bus. The local bus is 16 or 8 bits wide. Software loads a start internal byte address, a start local address, a byte count, a direction and a bus width, then pulses start. On each active cycle the engine moves one local-bus beat. A beat is one or two bytes. The internal address, the local address and the remaining count advance with every beat, and all three can be read at any moment.

An active-low external interrupt input can stop a running transfer. The input first passes through a two-flop synchronizer. When the interrupt feature is enabled, a low level has one of two effects, chosen by a continue-mode bit. With the bit clear, the transfer ends early with a done pulse. With the bit set, the engine freezes in a wait state: it stays busy, stops issuing beats and releases the shared data lines. It then continues from the same point once the input returns high. Because the counters are always readable, software can save the state after an early stop and later start a new transfer from the saved values.

After a transfer from the local bus to internal memory whose local start address and length do not end on a Dword boundary, the read-back internal address is pushed one Dword further on. The read-back remaining count is reduced to match.

Top module: `lbx_xfer_engine`

## Requirements
- R1: A start pulse with a nonzero length, seen while idle, loads the three counters and raises `active` from the next cycle. A start pulse with zero length, or any start pulse while `active` is high, is ignored.
- R2: In 16-bit mode a beat moves two bytes when at least two bytes remain and the internal byte offset (address bits 1:0) is not 3. Otherwise the beat moves one byte. In 8-bit mode every beat moves one byte. The byte at internal offset k sits on memory lane k (`mem_be[k]`, `mem_wdata[8k+7:8k]`). The lower-addressed byte of a beat sits on local data bits 7:0.
- R3: In the local-to-internal direction (`cfg_rd`=1), each beat writes the bytes taken from `lb_ad_i` to memory with `mem_we`=1. `mem_be` marks exactly the lanes used, and unused lanes of `mem_wdata` are zero.
- R4: In the internal-to-local direction (`cfg_rd`=0), each beat drives the selected bytes of `int_rdata` on `lb_ad_o` with `lb_ad_oe`=1. Bits 15:8 are zero on a one-byte beat, and `mem_we` stays 0.
- R5: On every beat, the local address and the internal address each grow by the beat's byte count and the remaining count shrinks by it. No counter changes in a cycle without a beat.
- R6: `done` is a one-cycle pulse in the cycle after the final beat, and `active` is low in that same cycle.
- R7: `ext_irq_n` passes through two synchronizer flops. A level change driven between clock edges reaches the control logic after the second following rising edge.
- R8: With `cfg_irq_en`=1 and `cfg_resume`=0, a synchronized low level while a transfer runs blocks any further beat. `done` pulses on the next cycle and `active` drops in that same cycle.
- R9: With `cfg_irq_en`=1 and `cfg_resume`=1, a synchronized low level puts the engine into a wait state. In that state `active` stays 1, no beats occur, `lb_ad_oe` is 0 and the counters hold. When the synchronized level returns high, the remaining beats continue in order.
- R10: With `cfg_irq_en`=0, `ext_irq_n` has no effect on the transfer.
- R11: The read-back values are live counters, with one exception. While idle after a local-to-internal transfer that was unaligned, `rb_int_addr` reads the internal address plus 4 and `rb_len` reads the remaining count minus 4, saturating at 0. `rb_loc_addr` is never adjusted. A transfer counts as aligned when the local start address bits 1:0 are 0, or when those bits plus the length bits 1:0 equal 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_irq_en | input | 1 | Enables the external interrupt halt |
| cfg_resume | input | 1 | 1: interrupt pauses; 0: interrupt aborts |
| cfg_wide | input | 1 | 1: 16-bit local bus; 0: 8-bit (latched at start) |
| cfg_rd | input | 1 | 1: local-to-internal; 0: internal-to-local (latched at start) |
| start | input | 1 | One-cycle start request |
| start_int_addr | input | IAW | Internal start byte address |
| start_loc_addr | input | LAW | Local start address |
| start_len | input | LENW | Byte count |
| ext_irq_n | input | 1 | Asynchronous active-low interrupt |
| active | output | 1 | Transfer in progress (including wait state) |
| done | output | 1 | One-cycle completion or abort pulse |
| lb_addr | output | LAW | Current local address of the beat |
| lb_strobe | output | 1 | A beat happens this cycle |
| lb_two | output | 1 | The beat carries two bytes |
| lb_ad_o | output | 16 | Local data driven in the internal-to-local direction |
| lb_ad_oe | output | 1 | Output enable of the local data lines |
| lb_ad_i | input | 16 | Local data received |
| mem_addr | output | IAW-2 | Internal Dword address of the beat |
| mem_be | output | 4 | Byte lanes used by the beat |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Memory write data |
| int_rdata | input | 32 | Memory read data for `mem_addr`, same cycle |
| rb_int_addr | output | IAW | Read-back internal address |
| rb_loc_addr | output | LAW | Read-back local address |
| rb_len | output | LENW | Read-back remaining count |

## Verification
The embedded properties check on every cycle that done is a single pulse with active low, that an abort leaves no further beat, that the counters hold still in the wait state, that the remaining count never grows outside a load, that a zero-length start stays idle, and that the lane count matches the beat size. Only the bench scenarios show the byte contents and lane placement, the exact number of beats let through by the synchronizer delay, the continuation order after a pause, and the read-back adjustment rules for aligned and unaligned transfers. They also show that a transfer restarted from saved read-back values picks up where the aborted one left off.

// File: rtl/lbx_pkg.sv
package lbx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } lbx_state_e;

  localparam int unsigned LBX_LANES     = 4;
  localparam int unsigned LBX_LOC_BYTES = 2;
endpackage

// File: rtl/lbx_sync.sv
// Multi-stage flop chain with selectable reset value; used for the
// interrupt input and for synchronous release of the reset.
module lbx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = d;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/lbx_ctrl.sv
module lbx_ctrl
  import lbx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       len_nz,
  input  logic       irq_en,
  input  logic       resume,
  input  logic       irq_n_s,
  input  logic       last_beat,
  output lbx_state_e state,
  output logic       beat,
  output logic       load,
  output logic       done
);
  lbx_state_e state_d;
  logic       fin_d;
  logic       halt_abort;
  logic       halt_pause;

  assign halt_abort = irq_en && !resume && !irq_n_s;
  assign halt_pause = irq_en &&  resume && !irq_n_s;

  always_comb begin
    state_d = state;
    fin_d   = 1'b0;
    beat    = 1'b0;
    load    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start && len_nz) begin
          load    = 1'b1;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (halt_abort) begin
          state_d = ST_IDLE;
          fin_d   = 1'b1;
        end else if (halt_pause) begin
          state_d = ST_WAIT;
        end else begin
          beat = 1'b1;
          if (last_beat) begin
            state_d = ST_IDLE;
            fin_d   = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (halt_abort) begin
          state_d = ST_IDLE;
          fin_d   = 1'b1;
        end else if (!halt_pause) begin
          state_d = ST_RUN;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_d;
      done  <= fin_d;
    end
  end

  // R8
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && irq_en && !resume && !irq_n_s) |=> (state == ST_IDLE && done));

  // R6
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start && !len_nz) |=> (state == ST_IDLE));
endmodule

// File: rtl/lbx_counters.sv
module lbx_counters #(
  parameter int IAW  = 32,
  parameter int LAW  = 16,
  parameter int LENW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            beat,
  input  logic            wide_i,
  input  logic            rd_i,
  input  logic [IAW-1:0]  ia_i,
  input  logic [LAW-1:0]  la_i,
  input  logic [LENW-1:0] len_i,
  output logic [IAW-1:0]  ia,
  output logic [LAW-1:0]  la,
  output logic [LENW-1:0] rem,
  output logic            two,
  output logic            last,
  output logic            rd,
  output logic            aligned
);
  logic            wide;
  logic [1:0]      step;
  logic            aligned_d;
  logic [2:0]      low_sum;
  logic [IAW-1:0]  ia_d;
  logic [LAW-1:0]  la_d;
  logic [LENW-1:0] rem_d;

  assign two  = wide && (rem >= LENW'(2)) && (ia[1:0] != 2'b11);
  assign step = two ? 2'd2 : 2'd1;
  assign last = (rem == LENW'(step));

  assign low_sum   = {1'b0, la_i[1:0]} + {1'b0, len_i[1:0]};
  assign aligned_d = (la_i[1:0] == 2'b00) || (low_sum == 3'd4);

  always_comb begin
    ia_d  = ia;
    la_d  = la;
    rem_d = rem;
    if (load) begin
      ia_d  = ia_i;
      la_d  = la_i;
      rem_d = len_i;
    end else if (beat) begin
      ia_d  = ia  + IAW'(step);
      la_d  = la  + LAW'(step);
      rem_d = rem - LENW'(step);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ia      <= '0;
      la      <= '0;
      rem     <= '0;
      wide    <= 1'b0;
      rd      <= 1'b0;
      aligned <= 1'b1;
    end else begin
      ia  <= ia_d;
      la  <= la_d;
      rem <= rem_d;
      if (load) begin
        wide    <= wide_i;
        rd      <= rd_i;
        aligned <= aligned_d;
      end
    end
  end

  // R5
  rem_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (rem <= $past(rem)));
endmodule

// File: rtl/lbx_lanes.sv
// Places beat bytes on internal lanes and picks them for the local bus.
module lbx_lanes
  import lbx_pkg::*;
(
  input  logic [1:0]  off,
  input  logic        two,
  input  logic [15:0] lb_in,
  input  logic [31:0] mem_in,
  output logic [3:0]  be,
  output logic [31:0] wdata,
  output logic [15:0] lb_out
);
  logic [1:0] off_hi;
  assign off_hi = off + 2'd1;

  always_comb begin
    be     = '0;
    wdata  = '0;
    lb_out = '0;
    for (int k = 0; k < int'(LBX_LANES); k++) begin
      if (off == 2'(k)) begin
        be[k]          = 1'b1;
        wdata[8*k +: 8] = lb_in[7:0];
        lb_out[7:0]    = mem_in[8*k +: 8];
      end
      if (two && (k != 0) && (off_hi == 2'(k))) begin
        be[k]          = 1'b1;
        wdata[8*k +: 8] = lb_in[15:8];
        lb_out[15:8]   = mem_in[8*k +: 8];
      end
    end
  end
endmodule

// File: rtl/lbx_xfer_engine.sv
module lbx_xfer_engine
  import lbx_pkg::*;
#(
  parameter int IAW         = 32,
  parameter int LAW         = 16,
  parameter int LENW        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_irq_en,
  input  logic            cfg_resume,
  input  logic            cfg_wide,
  input  logic            cfg_rd,
  input  logic            start,
  input  logic [IAW-1:0]  start_int_addr,
  input  logic [LAW-1:0]  start_loc_addr,
  input  logic [LENW-1:0] start_len,
  input  logic            ext_irq_n,
  output logic            active,
  output logic            done,
  output logic [LAW-1:0]  lb_addr,
  output logic            lb_strobe,
  output logic            lb_two,
  output logic [15:0]     lb_ad_o,
  output logic            lb_ad_oe,
  input  logic [15:0]     lb_ad_i,
  output logic [IAW-3:0]  mem_addr,
  output logic [3:0]      mem_be,
  output logic            mem_we,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     int_rdata,
  output logic [IAW-1:0]  rb_int_addr,
  output logic [LAW-1:0]  rb_loc_addr,
  output logic [LENW-1:0] rb_len
);
  localparam logic [IAW-1:0]  DW_STEP_A = IAW'(LBX_LANES);
  localparam logic [LENW-1:0] DW_STEP_L = LENW'(LBX_LANES);

  logic            rst_n_s;
  logic            irq_n_s;
  lbx_state_e      state;
  logic            beat;
  logic            load;
  logic            last;
  logic            two;
  logic            rd;
  logic            aligned;
  logic [IAW-1:0]  ia;
  logic [LAW-1:0]  la;
  logic [LENW-1:0] rem;
  logic [3:0]      be;
  logic [31:0]     wdata;
  logic [15:0]     lb_out;
  logic            adj;

  lbx_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rsync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_s)
  );

  lbx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_isync (
    .clk(clk), .rst_n(rst_n_s), .d(ext_irq_n), .q(irq_n_s)
  );

  lbx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .start(start), .len_nz(|start_len),
    .irq_en(cfg_irq_en), .resume(cfg_resume), .irq_n_s(irq_n_s),
    .last_beat(last), .state(state), .beat(beat), .load(load), .done(done)
  );

  lbx_counters #(.IAW(IAW), .LAW(LAW), .LENW(LENW)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .load(load), .beat(beat),
    .wide_i(cfg_wide), .rd_i(cfg_rd), .ia_i(start_int_addr),
    .la_i(start_loc_addr), .len_i(start_len), .ia(ia), .la(la),
    .rem(rem), .two(two), .last(last), .rd(rd), .aligned(aligned)
  );

  lbx_lanes u_lanes (
    .off(ia[1:0]), .two(two), .lb_in(lb_ad_i), .mem_in(int_rdata),
    .be(be), .wdata(wdata), .lb_out(lb_out)
  );

  assign active    = (state != ST_IDLE);
  assign lb_addr   = la;
  assign lb_strobe = beat;
  assign lb_two    = beat && two;
  assign mem_addr  = ia[IAW-1:2];
  assign mem_be    = beat ? be : 4'b0000;
  assign mem_we    = beat && rd;
  assign mem_wdata = (beat && rd) ? wdata : 32'h0;
  assign lb_ad_o   = (beat && !rd) ? lb_out : 16'h0;
  assign lb_ad_oe  = (state == ST_RUN) && !rd;

  assign adj         = !active && rd && !aligned;
  assign rb_int_addr = adj ? (ia + DW_STEP_A) : ia;
  assign rb_len      = adj ? ((rem > DW_STEP_L) ? (rem - DW_STEP_L) : '0) : rem;
  assign rb_loc_addr = la;

  // R2
  beat_width_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    lb_strobe |-> ($countones(mem_be) == (lb_two ? 2 : 1)));

  // R9
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state == ST_WAIT) |=> ($stable(rb_loc_addr) && $stable(ia) && $stable(rem)));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> !active);
endmodule

// File: tb/sim_lbx_xfer_engine.sv
module sim_lbx_xfer_engine;
  typedef struct packed {
    logic [15:0] la;
    logic [29:0] ma;
    logic [3:0]  be;
    logic [31:0] d;
  } beat_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_irq_en = 1'b0, cfg_resume = 1'b0, cfg_wide = 1'b0, cfg_rd = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_int_addr = '0;
  logic [15:0] start_loc_addr = '0;
  logic [15:0] start_len = '0;
  logic        ext_irq_n = 1'b1;
  logic        active, done, lb_strobe, lb_two, lb_ad_oe, mem_we;
  logic [15:0] lb_addr, lb_ad_o, lb_ad_i, rb_loc_addr, rb_len;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, int_rdata, rb_int_addr;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  logic cur_rd = 1'b0;
  beat_t exp_q[$];

  function automatic logic [7:0] lbyte(input logic [15:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] ibyte(input logic [31:0] b);
    return b[7:0] ^ 8'hC3;
  endfunction

  always #5 clk = ~clk;

  assign lb_ad_i   = {lbyte(lb_addr + 16'd1), lbyte(lb_addr)};
  assign int_rdata = {ibyte({mem_addr, 2'd3}), ibyte({mem_addr, 2'd2}),
                      ibyte({mem_addr, 2'd1}), ibyte({mem_addr, 2'd0})};

  lbx_xfer_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_irq_en(cfg_irq_en), .cfg_resume(cfg_resume),
    .cfg_wide(cfg_wide), .cfg_rd(cfg_rd), .start(start),
    .start_int_addr(start_int_addr), .start_loc_addr(start_loc_addr),
    .start_len(start_len), .ext_irq_n(ext_irq_n), .active(active), .done(done),
    .lb_addr(lb_addr), .lb_strobe(lb_strobe), .lb_two(lb_two), .lb_ad_o(lb_ad_o),
    .lb_ad_oe(lb_ad_oe), .lb_ad_i(lb_ad_i), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .int_rdata(int_rdata),
    .rb_int_addr(rb_int_addr), .rb_loc_addr(rb_loc_addr), .rb_len(rb_len)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: builds the expected beat list (R2, R3, R4, R5) and queues it.
  task automatic plan(input logic [31:0] ia0, input logic [15:0] la0,
                      input logic [15:0] len, input logic wide, input logic rd,
                      input int limit);
    logic [31:0] ia = ia0;
    logic [15:0] la = la0;
    logic [15:0] rem = len;
    int n = 0;
    while (rem != 0 && n < limit) begin
      beat_t b;
      logic s2;
      logic [1:0] l;
      s2 = wide && (rem >= 2) && (ia[1:0] != 2'b11);
      l  = ia[1:0];
      b.la = la;
      b.ma = ia[31:2];
      b.be = s2 ? (4'b0011 << l) : (4'b0001 << l);
      b.d  = '0;
      if (rd) begin
        b.d[8*l +: 8] = lbyte(la);
        if (s2) b.d[8*(l+1) +: 8] = lbyte(la + 16'd1);
      end else begin
        b.d[7:0] = ibyte(ia);
        if (s2) b.d[15:8] = ibyte(ia + 32'd1);
      end
      exp_q.push_back(b);
      ia  = ia + (s2 ? 32'd2 : 32'd1);
      la  = la + (s2 ? 16'd2 : 16'd1);
      rem = rem - (s2 ? 16'd2 : 16'd1);
      n++;
    end
  endtask

  // Monitor: compares each beat with the head of the queue.
  always @(negedge clk) begin
    if (rst_n && lb_strobe) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 R7 unexpected beat", {48'h0, lb_addr}, 64'h0);
      end else begin
        beat_t e;
        beat_t a;
        e = exp_q.pop_front();
        a.la = lb_addr;
        a.ma = mem_addr;
        a.be = mem_be;
        a.d  = cur_rd ? mem_wdata : {16'h0, lb_ad_o};
        if (cur_rd) chk(a == e && mem_we, "R2 R3 R5 read beat", a[63:0], e[63:0]);
        else        chk(a == e && !mem_we && lb_ad_oe, "R2 R4 R5 write beat", a[63:0], e[63:0]);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic go(input logic [31:0] ia, input logic [15:0] la,
                    input logic [15:0] len, input logic wide, input logic rd);
    @(negedge clk);
    cfg_wide = wide; cfg_rd = rd; cur_rd = rd;
    start_int_addr = ia; start_loc_addr = la; start_len = len;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int t = 0;
    while (!done && t < 500) begin
      @(negedge clk);
      t++;
    end
    chk(done && !active, {tag, " R6 done with active low"}, {62'h0, done, active}, 64'h2);
    @(negedge clk);
    chk(!done, {tag, " R6 single done pulse"}, {63'h0, done}, 64'h0);
  endtask

  task automatic rb_chk(input string tag, input logic [31:0] ei,
                        input logic [15:0] el, input logic [15:0] en);
    chk(rb_int_addr == ei, {tag, " rb_int_addr"}, {32'h0, rb_int_addr}, {32'h0, ei});
    chk(rb_loc_addr == el, {tag, " rb_loc_addr"}, {48'h0, rb_loc_addr}, {48'h0, el});
    chk(rb_len == en, {tag, " rb_len"}, {48'h0, rb_len}, {48'h0, en});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!active && !done && !lb_ad_oe && !lb_strobe, "R1 reset idle",
        {60'h0, active, done, lb_ad_oe, lb_strobe}, 64'h0);
    rb_chk("R1 reset", 32'h0, 16'h0, 16'h0);

    // A: internal-to-local, 16-bit, unaligned but not a read (R4 R11)
    plan(32'h100, 16'h41, 16'd9, 1'b1, 1'b0, 1000);
    go(32'h100, 16'h41, 16'd9, 1'b1, 1'b0);
    wait_done("A");
    chk(exp_q.size() == 0, "R5 A all beats", exp_q.size(), 0);
    rb_chk("R11 A write no adjust", 32'h109, 16'h4A, 16'h0);

    // B: local-to-internal, 16-bit, odd offset, aligned (R2 R3 R11)
    plan(32'h201, 16'h10, 16'd7, 1'b1, 1'b1, 1000);
    go(32'h201, 16'h10, 16'd7, 1'b1, 1'b1);
    wait_done("B");
    chk(exp_q.size() == 0, "R2 B all beats", exp_q.size(), 0);
    rb_chk("R11 B aligned", 32'h208, 16'h17, 16'h0);

    // C: local-to-internal, 8-bit, unaligned (R2 R11)
    plan(32'h300, 16'h11, 16'd6, 1'b0, 1'b1, 1000);
    go(32'h300, 16'h11, 16'd6, 1'b0, 1'b1);
    wait_done("C");
    chk(exp_q.size() == 0, "R2 C all beats", exp_q.size(), 0);
    rb_chk("R11 C unaligned adjust", 32'h30A, 16'h17, 16'h0);

    // D: zero-length start ignored (R1)
    go(32'h900, 16'h55, 16'd0, 1'b1, 1'b1);
    chk(!active, "R1 zero length ignored", {63'h0, active}, 64'h0);
    @(negedge clk);
    chk(!active && !lb_strobe, "R1 zero length stays idle", {62'h0, active, lb_strobe}, 64'h0);

    // E: abort, aligned read, then restart from read-back (R7 R8 R11)
    cfg_irq_en = 1'b1; cfg_resume = 1'b0;
    plan(32'h400, 16'h23, 16'd21, 1'b1, 1'b1, 2);
    go(32'h400, 16'h23, 16'd21, 1'b1, 1'b1);
    ext_irq_n = 1'b0;
    wait_done("R8 E abort");
    ext_irq_n = 1'b1;
    chk(exp_q.size() == 0, "R7 R8 E two beats before stop", exp_q.size(), 0);
    rb_chk("R11 E aligned after abort", 32'h404, 16'h27, 16'd17);
    repeat (4) @(negedge clk);
    plan(32'h404, 16'h27, 16'd17, 1'b1, 1'b1, 1000);
    go(32'h404, 16'h27, 16'd17, 1'b1, 1'b1);
    wait_done("R11 E restart");
    chk(exp_q.size() == 0, "R11 E restart finished", exp_q.size(), 0);
    rb_chk("R11 E restart", 32'h415, 16'h38, 16'h0);

    // E2: abort of unaligned read adjusts address and count (R8 R11)
    plan(32'h500, 16'h01, 16'd20, 1'b1, 1'b1, 2);
    go(32'h500, 16'h01, 16'd20, 1'b1, 1'b1);
    ext_irq_n = 1'b0;
    wait_done("R8 E2 abort");
    ext_irq_n = 1'b1;
    chk(exp_q.size() == 0, "R8 E2 beats", exp_q.size(), 0);
    rb_chk("R11 E2 unaligned abort", 32'h508, 16'h05, 16'd12);
    repeat (4) @(negedge clk);

    // F: pause with released data lines, start ignored while busy (R9 R1)
    cfg_resume = 1'b1;
    plan(32'h600, 16'h80, 16'd12, 1'b1, 1'b0, 1000);
    go(32'h600, 16'h80, 16'd12, 1'b1, 1'b0);
    ext_irq_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      chk(active && !lb_strobe && !lb_ad_oe, "R9 wait state",
          {61'h0, active, lb_strobe, lb_ad_oe}, 64'h4);
      if (i == 1) begin
        start_int_addr = 32'hA00; start_loc_addr = 16'h0; start_len = 16'd3;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(rb_loc_addr == 16'h84, "R9 R1 counters held", {48'h0, rb_loc_addr}, 64'h84);
    ext_irq_n = 1'b1;
    wait_done("R9 F resume");
    chk(exp_q.size() == 0, "R9 F resumed in order", exp_q.size(), 0);
    rb_chk("R9 F end", 32'h60C, 16'h8C, 16'h0);

    // G: interrupt disabled, input ignored (R10)
    cfg_irq_en = 1'b0; cfg_resume = 1'b0;
    plan(32'h700, 16'h90, 16'd5, 1'b0, 1'b0, 1000);
    go(32'h700, 16'h90, 16'd5, 1'b0, 1'b0);
    ext_irq_n = 1'b0;
    wait_done("R10 G");
    ext_irq_n = 1'b1;
    chk(exp_q.size() == 0, "R10 G all beats despite low input", exp_q.size(), 0);
    rb_chk("R10 G end", 32'h705, 16'h95, 16'h0);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule